// File: doc/BRIEF.md
# Timer Read-Back Latch Unit

This block sits between a host bus and the three counter cores of a programmable interval timer. It turns the host's chip-select, read strobe, write strobe and 2-bit address into one-cycle write pulses for each channel's data register, a pulse for ordinary control words, and byte reads from the channels. Every bus strobe is sampled on the system clock. One action is taken when a strobe becomes active, so a strobe held for several cycles acts only once.

A control word whose two top bits are both set is a read-back command, and this block handles it itself. Such a command freezes the live 16-bit count and/or an 8-bit status byte of any subset of the three channels into per-channel holding latches. Each frozen value is kept until the host has read all of it. A latch that still holds unread data ignores further capture requests, while the other selected channels still capture. When nothing is frozen, a channel read returns the live count, low byte then high byte.

Top module: `tmr_readback_unit`

## Requirements
- R1: With cs_n=0, rd_n=1 and wr_n=0, addresses 0, 1 and 2 give a single one-cycle pulse on chan_wr bit 0, 1 or 2 per write access. wr_data carries din in that same cycle. The pulse appears in the cycle after the clock edge that first samples the write.
- R2: A write to address 3 whose din[7:6] is not 2'b11 gives a one-cycle ctrl_wr pulse. A read-back command (din[7:6]=2'b11) gives no ctrl_wr pulse and no chan_wr pulse.
- R3: After reset, and whenever cs_n=1, or rd_n and wr_n are both 1, or a read targets address 3, dout_en stays 0 and no write pulse occurs. A read of address 0 to 2 raises dout_en from the clock edge that first samples it for as long as the read is held.
- R4: In a read-back command, din[5]=0 requests a count capture. Bits din[3], din[2] and din[1] select channels 2, 1 and 0. The selected channel's live count at the command's sampling edge is held and returned low byte first, then high byte, whatever the live count does afterwards.
- R5: din[4]=0 requests a status capture. The held byte is {out level at bit 7, null-count flag at bit 6, six mode bits at bits 5:0} of that channel at the sampling edge.
- R6: When both status and count are held for a channel, the first read returns the status byte, and the next two reads return the count low byte and then the high byte.
- R7: A status request for a channel whose status is still held and unread is ignored for that channel. The held byte is unchanged, and a count request in the same command is still captured.
- R8: A count request for a channel whose count is still held and unread is ignored. The original held count is returned.
- R9: A latch releases once fully read. Reads with nothing held return the live count, alternating low byte and high byte, starting from the low byte after reset or after a release.
- R10: One read-back command captures every selected channel, each with its own live value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register address: channel 0..2, or 3 for the control word |
| din | input | 8 | Write data from host |
| live_count | input | 48 | Live 16-bit counts, channel i at bits 16*i+15:16*i |
| ch_out | input | 3 | Output level of each channel |
| ch_null | input | 3 | Null-count flag of each channel |
| ch_mode | input | 18 | Six programmed mode bits per channel, channel i at 6*i+5:6*i |
| dout | output | 8 | Read data to host |
| dout_en | output | 1 | Read data enable for the pad driver |
| chan_wr | output | 3 | One-cycle write pulse per channel |
| ctrl_wr | output | 1 | One-cycle pulse for a non-read-back control word |
| wr_data | output | 8 | Registered write data accompanying the pulses |

## Verification
Read-back commands are tried as count-only, status-only, count-plus-status, and with one or all three channels selected. This separates the request-bit decoding from the channel-select decoding. The live inputs are changed after each capture, so a latch that tracks live values instead of holding them returns a different byte. Commands aimed at latches that are still full separate the skip-if-held rule from plain recapture. Live reads before and after release show whether the byte toggle restarts correctly.

// File: rtl/tmr_rb_pkg.sv
package tmr_rb_pkg;
  localparam int NCH       = 3;
  localparam int DW        = 8;
  localparam int CW        = 2 * DW;
  localparam int MODE_W    = DW - 2;
  localparam int AW        = 2;
  localparam logic [AW-1:0] CTRL_ADDR = '1;

  function automatic logic [DW-1:0] status_byte(input logic out_lvl,
                                                 input logic null_flag,
                                                 input logic [MODE_W-1:0] mode);
    return {out_lvl, null_flag, mode};
  endfunction
endpackage

// File: rtl/tmr_bus_decode.sv
module tmr_bus_decode
  import tmr_rb_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           cs_n,
  input  logic           rd_n,
  input  logic           wr_n,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  din,
  output logic           rd_active,
  output logic           rd_start,
  output logic           rb_fire,
  output logic           rb_cnt,
  output logic           rb_st,
  output logic [NCH-1:0] rb_sel,
  output logic [NCH-1:0] chan_wr,
  output logic           ctrl_wr,
  output logic [DW-1:0]  wr_data
);
  logic wr_active, wr_q, rd_q, wr_start, ctrl_sel, rb_hit;

  assign wr_active = ~cs_n & rd_n & ~wr_n;
  assign rd_active = ~cs_n & ~rd_n & wr_n;
  assign wr_start  = wr_active & ~wr_q;
  assign rd_start  = rd_active & ~rd_q;
  assign ctrl_sel  = (addr == CTRL_ADDR);
  assign rb_hit    = (din[DW-1:DW-2] == 2'b11);
  assign rb_fire   = wr_start & ctrl_sel & rb_hit;
  assign rb_cnt    = ~din[5];
  assign rb_st     = ~din[4];
  assign rb_sel    = din[NCH:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      chan_wr <= '0;
      ctrl_wr <= 1'b0;
      wr_data <= '0;
    end else begin
      wr_q    <= wr_active;
      rd_q    <= rd_active;
      ctrl_wr <= wr_start & ctrl_sel & ~rb_hit;
      if (wr_start) wr_data <= din;
      for (int i = 0; i < NCH; i++)
        chan_wr[i] <= wr_start & (addr == AW'(i));
    end
  end

  a_r1_single_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({chan_wr, ctrl_wr}));
  a_r1_one_pulse: assert property (@(posedge clk) disable iff (rst)
    (chan_wr != '0) |=> (chan_wr == '0));
endmodule

// File: rtl/tmr_chan_latch.sv
module tmr_chan_latch
  import tmr_rb_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          cap,
  input  logic          req_cnt,
  input  logic          req_st,
  input  logic [CW-1:0] live_cnt,
  input  logic [DW-1:0] live_st,
  input  logic          rd_sel,
  output logic [DW-1:0] rd_byte
);
  logic          cnt_held, st_held, hi_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_held <= 1'b0;
      st_held  <= 1'b0;
      hi_q     <= 1'b0;
      cnt_q    <= '0;
      st_q     <= '0;
    end else if (cap) begin
      if (req_st && !st_held) begin
        st_held <= 1'b1;
        st_q    <= live_st;
      end
      if (req_cnt && !cnt_held) begin
        cnt_held <= 1'b1;
        cnt_q    <= live_cnt;
        hi_q     <= 1'b0;
      end
    end else if (rd_sel) begin
      if (st_held) begin
        st_held <= 1'b0;
      end else if (cnt_held) begin
        if (hi_q) begin
          cnt_held <= 1'b0;
          hi_q     <= 1'b0;
        end else begin
          hi_q <= 1'b1;
        end
      end else begin
        hi_q <= ~hi_q;
      end
    end
  end

  always_comb begin
    if (st_held)       rd_byte = st_q;
    else if (cnt_held) rd_byte = hi_q ? cnt_q[CW-1:DW] : cnt_q[DW-1:0];
    else               rd_byte = hi_q ? live_cnt[CW-1:DW] : live_cnt[DW-1:0];
  end

  // R4 / R8: held count stays frozen until read
  a_r4_cnt_hold: assert property (@(posedge clk) disable iff (rst)
    (cnt_held && !rd_sel) |=> (cnt_held && $stable(cnt_q)));
  // R7: held status stays frozen until read
  a_r7_st_hold: assert property (@(posedge clk) disable iff (rst)
    (st_held && !rd_sel) |=> (st_held && $stable(st_q)));
  // R6: status leaves first, count untouched by that read
  a_r6_status_first: assert property (@(posedge clk) disable iff (rst)
    (rd_sel && st_held && !cap) |=> (!st_held && $stable(cnt_held) && $stable(hi_q)));
endmodule

// File: rtl/tmr_readback_unit.sv
module tmr_readback_unit
  import tmr_rb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [1:0]        addr,
  input  logic [7:0]        din,
  input  logic [47:0]       live_count,
  input  logic [2:0]        ch_out,
  input  logic [2:0]        ch_null,
  input  logic [17:0]       ch_mode,
  output logic [7:0]        dout,
  output logic              dout_en,
  output logic [2:0]        chan_wr,
  output logic              ctrl_wr,
  output logic [7:0]        wr_data
);
  logic           rd_active, rd_start, rb_fire, rb_cnt, rb_st;
  logic [NCH-1:0] rb_sel;
  logic [DW-1:0]  rd_byte [NCH];
  logic           rd_valid_addr;

  assign rd_valid_addr = (addr != CTRL_ADDR);

  tmr_bus_decode u_dec (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(din),
    .rd_active(rd_active), .rd_start(rd_start),
    .rb_fire(rb_fire), .rb_cnt(rb_cnt), .rb_st(rb_st), .rb_sel(rb_sel),
    .chan_wr(chan_wr), .ctrl_wr(ctrl_wr), .wr_data(wr_data)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    tmr_chan_latch u_lat (
      .clk(clk), .rst(rst),
      .cap(rb_fire & rb_sel[g]),
      .req_cnt(rb_cnt), .req_st(rb_st),
      .live_cnt(live_count[g*CW +: CW]),
      .live_st(status_byte(ch_out[g], ch_null[g], ch_mode[g*MODE_W +: MODE_W])),
      .rd_sel(rd_start & (addr == AW'(g))),
      .rd_byte(rd_byte[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= '0;
      dout_en <= 1'b0;
    end else begin
      dout_en <= rd_active & rd_valid_addr;
      if (rd_start && rd_valid_addr) dout <= rd_byte[addr];
    end
  end

  a_r3_idle_bus: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> !dout_en);
  a_r3_no_ctrl_read: assert property (@(posedge clk) disable iff (rst)
    (addr == CTRL_ADDR) |=> !dout_en);
  a_r2_rb_silent: assert property (@(posedge clk) disable iff (rst)
    rb_fire |=> (!ctrl_wr && chan_wr == '0));
endmodule

// File: tb/tmr_readback_unit_test.sv
module tmr_readback_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0]  addr = '0;
  logic [7:0]  din = '0;
  logic [15:0] c0 = 16'h1234, c1 = 16'hABCD, c2 = 16'h0F0E;
  logic [2:0]  ch_out = 3'b101, ch_null = 3'b010;
  logic [5:0]  m0 = 6'h36, m1 = 6'h14, m2 = 6'h2A;
  logic [7:0]  dout;
  logic        dout_en;
  logic [2:0]  chan_wr;
  logic        ctrl_wr;
  logic [7:0]  wr_data;

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       prev_en = 1'b0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  tmr_readback_unit uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(din), .live_count({c2, c1, c0}),
    .ch_out(ch_out), .ch_null(ch_null), .ch_mode({m2, m1, m0}),
    .dout(dout), .dout_en(dout_en), .chan_wr(chan_wr),
    .ctrl_wr(ctrl_wr), .wr_data(wr_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected byte per read
  always @(negedge clk) begin
    if (dout_en && !prev_en) begin
      if (exp_q.size() == 0) chk("R3 unexpected read data", 32'(dout), 32'hFFFF_FFFF);
      else begin
        automatic string t = tag_q.pop_front();
        automatic logic [7:0] e = exp_q.pop_front();
        chk(t, 32'(dout), 32'(e));
      end
    end
    prev_en <= dout_en;
  end

  task automatic do_read(input logic [1:0] a, input logic [7:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk); cs_n = 0; rd_n = 0; addr = a;
    @(negedge clk);
    @(negedge clk); cs_n = 1; rd_n = 1;
    @(negedge clk);
  endtask

  task automatic do_write(input logic [1:0] a, input logic [7:0] d,
                          input logic [2:0] ecw, input logic ectl, input string tag);
    @(negedge clk); cs_n = 0; wr_n = 0; addr = a; din = d;
    @(negedge clk);
    chk(tag, {28'd0, chan_wr, ctrl_wr}, {28'd0, ecw, ectl});
    if (ecw != 0 || ectl) chk(tag, 32'(wr_data), 32'(d));
    @(negedge clk);
    chk(tag, {28'd0, chan_wr, ctrl_wr}, 32'd0);
    cs_n = 1; wr_n = 1;
    @(negedge clk);
  endtask

  task automatic idle_noop(input logic c, input logic r, input logic w,
                           input logic [1:0] a, input string tag);
    @(negedge clk); cs_n = c; rd_n = r; wr_n = w; addr = a;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(tag, {28'd0, dout_en, chan_wr}, 32'd0);
    end
    cs_n = 1; rd_n = 1; wr_n = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R3 reset outputs", {24'd0, dout_en, chan_wr, ctrl_wr}, 32'd0);

    // R1 channel writes, R2 control word
    do_write(2'd0, 8'h5A, 3'b001, 1'b0, "R1 write ch0");
    do_write(2'd1, 8'hC3, 3'b010, 1'b0, "R1 write ch1");
    do_write(2'd2, 8'h7E, 3'b100, 1'b0, "R1 write ch2");
    do_write(2'd3, 8'h34, 3'b000, 1'b1, "R2 plain control word");

    // R9 live reads
    do_read(2'd0, 8'h34, "R9 live low");
    do_read(2'd0, 8'h12, "R9 live high");

    // R4 count-only on ch0
    do_write(2'd3, 8'hD2, 3'b000, 1'b0, "R2 read-back no ctrl_wr");
    c0 = 16'h5555;
    do_read(2'd0, 8'h34, "R4 held low");
    do_read(2'd0, 8'h12, "R4 held high");
    do_read(2'd0, 8'h55, "R9 live after release");
    do_read(2'd0, 8'h55, "R9 live after release hi");

    // R5 status-only on ch1: {0,1,14} = 0x54
    do_write(2'd3, 8'hE4, 3'b000, 1'b0, "R2 status cmd");
    ch_null = 3'b000; c1 = 16'h2211;
    do_read(2'd1, 8'h54, "R5 status byte");
    do_read(2'd1, 8'h11, "R9 live after status");
    do_read(2'd1, 8'h22, "R9 live after status hi");

    // R6 both on ch2: status {1,0,2A} = 0xAA
    do_write(2'd3, 8'hC8, 3'b000, 1'b0, "R2 both cmd");
    c2 = 16'h7777; ch_out = 3'b001;
    do_read(2'd2, 8'hAA, "R6 status first");
    do_read(2'd2, 8'h0E, "R6 count low");
    do_read(2'd2, 8'h0F, "R6 count high");
    do_read(2'd2, 8'h77, "R9 ch2 live");
    do_read(2'd2, 8'h77, "R9 ch2 live hi");

    // R7: ch1 status held, second request ignored, ch2 still latches
    ch_null = 3'b010;
    do_write(2'd3, 8'hE4, 3'b000, 1'b0, "R2 status ch1");
    ch_null = 3'b000;
    do_write(2'd3, 8'hEC, 3'b000, 1'b0, "R2 status ch1 ch2");
    do_write(2'd3, 8'hC4, 3'b000, 1'b0, "R2 both ch1");
    c1 = 16'h9999;
    do_read(2'd1, 8'h54, "R7 old status kept");
    do_read(2'd1, 8'h11, "R7 count still captured low");
    do_read(2'd1, 8'h22, "R7 count still captured high");
    do_read(2'd2, 8'h2A, "R10 other channel latched status");

    // R8: count held, recapture ignored
    c0 = 16'h1357;
    do_write(2'd3, 8'hD2, 3'b000, 1'b0, "R2 count ch0");
    c0 = 16'h2468;
    do_write(2'd3, 8'hD2, 3'b000, 1'b0, "R2 count ch0 again");
    do_read(2'd0, 8'h57, "R8 original count low");
    do_read(2'd0, 8'h13, "R8 original count high");

    // R10: all three counts at once
    c0 = 16'hA0A1; c1 = 16'hB0B1; c2 = 16'hC0C1;
    do_write(2'd3, 8'hDE, 3'b000, 1'b0, "R2 count all");
    c0 = 16'h0; c1 = 16'h0; c2 = 16'h0;
    do_read(2'd2, 8'hC1, "R10 ch2 low");
    do_read(2'd0, 8'hA1, "R10 ch0 low");
    do_read(2'd1, 8'hB1, "R10 ch1 low");
    do_read(2'd1, 8'hB0, "R10 ch1 high");
    do_read(2'd0, 8'hA0, "R10 ch0 high");
    do_read(2'd2, 8'hC0, "R10 ch2 high");

    // R3 no-operation cases
    idle_noop(1'b1, 1'b0, 1'b1, 2'd0, "R3 cs high read");
    idle_noop(1'b1, 1'b1, 1'b0, 2'd1, "R3 cs high write");
    idle_noop(1'b0, 1'b1, 1'b1, 2'd2, "R3 no strobe");
    idle_noop(1'b0, 1'b0, 1'b1, 2'd3, "R3 read address 3");

    repeat (4) @(negedge clk);
    chk("R3 all reads answered", 32'(exp_q.size()), 32'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule